// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Flags

This block sits beside the time-of-day counters of a real-time clock. It holds three alarm values, one each for seconds, minutes and hours. At the end of every update cycle it compares them with the running time fields. An alarm value with its two top bits set is a wildcard and matches any value of its field. A full match sets the alarm flag.

The block also records a periodic-tick flag and an update-done flag. A control register enables each of the three sources separately. A status register shows the three flags and a summary bit. That summary bit is set whenever an enabled flag is active, and it drives the interrupt request line. Reading the status register clears every flag. A flag event that lands in the same cycle as the read still leaves its flag set.

Software reaches the registers through a simple register bus. Writes take effect at the clock edge. Reads are combinational from the current register state.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset every alarm register, the control register and all flags are zero, and `irq` is low.
- R2: The seconds, minutes and hours alarm registers sit at indices 1, 3 and 5, and the control register at index 11. Each is written in full by a bus write and reads back the value written. Control bit 6 enables the periodic source, bit 5 the alarm source and bit 4 the update source.
- R3: An `upd_done` strobe sets the update flag.
- R4: On an `upd_done` strobe, the alarm flag is set when all three fields match. Without the strobe, no comparison takes place.
- R5: An alarm register whose bits 7 and 6 are both 1 matches any value of its time field.
- R6: A `tick` strobe sets the periodic flag.
- R7: The status register at index 12 reads the periodic, alarm and update flags at bits 6, 5 and 4. Bit 7 is 1 exactly when some flag is set together with its enable. Bits 3 to 0 read 0. Any other index reads 0.
- R8: A read of index 12 clears all three flags at the next edge, so `irq` falls in the cycle after the read.
- R9: A flag event in the same cycle as a status read leaves that flag set.
- R10: `irq` equals status bit 7. A flag is still set while its enable is clear, but it does not raise `irq`.
- R11: A bus write to index 12 or to an unused index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec | input | 8 | Current seconds field |
| min | input | 8 | Current minutes field |
| hour | input | 8 | Current hours field |
| upd_done | input | 1 | One-cycle strobe at the end of an update cycle |
| tick | input | 1 | One-cycle periodic-tick strobe |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request, high when status bit 7 is set |

## Verification
A wrong flag or a wrong alarm value becomes visible on `irq` in the same cycle, as long as the matching enable is set. Otherwise it shows at the next read of the status register, and the clear-on-read then makes the following read expose any clear that was missed. The bench compares every read and the `irq` level in every cycle against a model. Wildcard alarms, events that collide with reads, and strobes that arrive while an enable is clear can therefore be traced back to the exact cycle where the design went wrong.

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int SEC_IDX = 1,
  parameter int MIN_IDX = 3,
  parameter int HR_IDX  = 5,
  parameter int CTL_IDX = 11,
  parameter int FLG_IDX = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sec,
  input  logic [DW-1:0] min,
  input  logic [DW-1:0] hour,
  input  logic          upd_done,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [1:0] WILD = 2'b11;

  logic [DW-1:0] alm_s, alm_m, alm_h, ctl;
  logic pf, af, uf;

  function automatic logic fmatch(input logic [DW-1:0] a, input logic [DW-1:0] t);
    return (a[DW-1:DW-2] == WILD) || (a == t);
  endfunction

  wire hit    = fmatch(alm_s, sec) && fmatch(alm_m, min) && fmatch(alm_h, hour);
  wire rd_clr = rd_en && (addr == AW'(FLG_IDX));
  wire any_en = (pf && ctl[6]) || (af && ctl[5]) || (uf && ctl[4]);
  wire [DW-1:0] status = {any_en, pf, af, uf, {(DW-4){1'b0}}};

  assign irq = status[DW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alm_s <= '0; alm_m <= '0; alm_h <= '0; ctl <= '0;
    end else if (wr_en) begin
      if (addr == AW'(SEC_IDX)) alm_s <= wdata;
      if (addr == AW'(MIN_IDX)) alm_m <= wdata;
      if (addr == AW'(HR_IDX))  alm_h <= wdata;
      if (addr == AW'(CTL_IDX)) ctl   <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf <= 1'b0; af <= 1'b0; uf <= 1'b0;
    end else begin
      pf <= tick ? 1'b1 : (rd_clr ? 1'b0 : pf);
      uf <= upd_done ? 1'b1 : (rd_clr ? 1'b0 : uf);
      af <= (upd_done && hit) ? 1'b1 : (rd_clr ? 1'b0 : af);
    end

  always_comb begin
    rdata = '0;
    if (addr == AW'(SEC_IDX)) rdata = alm_s;
    if (addr == AW'(MIN_IDX)) rdata = alm_m;
    if (addr == AW'(HR_IDX))  rdata = alm_h;
    if (addr == AW'(CTL_IDX)) rdata = ctl;
    if (addr == AW'(FLG_IDX)) rdata = status;
  end

  assert_upd_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> uf);
  assert_tick_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pf);
  assert_wild_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && alm_s[DW-1:DW-2] == WILD && alm_m[DW-1:DW-2] == WILD && alm_h[DW-1:DW-2] == WILD) |=> af);
  assert_no_compare_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_done && !rd_clr) |=> $stable(af));
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !tick && !upd_done) |=> !irq);
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && tick) |=> pf);
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick || upd_done || wr_en));
endmodule

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] sec = 0, min = 0, hour = 0, wdata = 0;
  logic upd_done = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_as = 0, m_am = 0, m_ah = 0, m_ctl = 0;
  logic m_pf = 0, m_af = 0, m_uf = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (.clk, .rst_n, .sec, .min, .hour, .upd_done, .tick,
    .wr_en, .rd_en, .addr, .wdata, .rdata, .irq);

  function automatic logic mt(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  function automatic logic [7:0] exp_status();
    logic b7;
    b7 = (m_pf && m_ctl[6]) || (m_af && m_ctl[5]) || (m_uf && m_ctl[4]);
    return {b7, m_pf, m_af, m_uf, 4'b0000};
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd1: return m_as;
      4'd3: return m_am;
      4'd5: return m_ah;
      4'd11: return m_ctl;
      4'd12: return exp_status();
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d,
                      input logic u, input logic t, input string tag);
    logic hit, clr;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; upd_done = u; tick = t;
    #2;
    if (r) chk(rdata == exp_read(a), tag, rdata, exp_read(a));
    chk(irq == exp_status()[7], "R10 irq", {7'd0, irq}, {7'd0, exp_status()[7]});
    hit = mt(m_as, sec) && mt(m_am, min) && mt(m_ah, hour);
    clr = r && (a == 4'd12);
    @(posedge clk); #1;
    m_pf = t ? 1'b1 : (clr ? 1'b0 : m_pf);
    m_uf = u ? 1'b1 : (clr ? 1'b0 : m_uf);
    m_af = (u && hit) ? 1'b1 : (clr ? 1'b0 : m_af);
    if (w) case (a)
      4'd1: m_as = d; 4'd3: m_am = d; 4'd5: m_ah = d; 4'd11: m_ctl = d;
      default: ;
    endcase
    wr_en = 0; rd_en = 0; upd_done = 0; tick = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #20;
    chk(irq == 1'b0, "R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1;
    step(0, 1, 4'd1, 0, 0, 0, "R1 sec alarm reset");
    step(0, 1, 4'd3, 0, 0, 0, "R1 min alarm reset");
    step(0, 1, 4'd5, 0, 0, 0, "R1 hour alarm reset");
    step(0, 1, 4'd11, 0, 0, 0, "R1 control reset");
    step(0, 1, 4'd12, 0, 0, 0, "R1 status reset");
    step(1, 0, 4'd1, 8'h30, 0, 0, "R2");
    step(1, 0, 4'd3, 8'h15, 0, 0, "R2");
    step(1, 0, 4'd5, 8'h07, 0, 0, "R2");
    step(1, 0, 4'd11, 8'h70, 0, 0, "R2");
    step(0, 1, 4'd1, 0, 0, 0, "R2 sec alarm readback");
    step(0, 1, 4'd3, 0, 0, 0, "R2 min alarm readback");
    step(0, 1, 4'd5, 0, 0, 0, "R2 hour alarm readback");
    step(0, 1, 4'd11, 0, 0, 0, "R2 control readback");
    step(1, 0, 4'd12, 8'hFF, 0, 0, "R11 write to status");
    step(1, 0, 4'd9, 8'hFF, 0, 0, "R11 write unused");
    step(0, 1, 4'd12, 0, 0, 0, "R11 status untouched");
    step(0, 1, 4'd11, 0, 0, 0, "R11 control untouched");
    step(0, 1, 4'd9, 0, 0, 0, "R7 unused index reads zero");
    sec = 8'h30; min = 8'h15; hour = 8'h07;
    step(0, 0, 0, 0, 0, 0, "R4 no strobe no compare");
    step(0, 1, 4'd12, 0, 0, 0, "R4 alarm flag clear without strobe");
    sec = 8'h31;
    step(0, 0, 0, 0, 1, 0, "R3 update sets flag");
    step(0, 1, 4'd12, 0, 0, 0, "R3 update flag, no alarm on mismatch");
    step(0, 1, 4'd12, 0, 0, 0, "R8 flags cleared by read");
    sec = 8'h30;
    step(0, 0, 0, 0, 1, 0, "R4 match");
    step(0, 1, 4'd12, 0, 0, 0, "R4 alarm flag set on match");
    step(1, 0, 4'd1, 8'hC5, 0, 0, "R5");
    step(1, 0, 4'd3, 8'hFF, 0, 0, "R5");
    sec = 8'h59; min = 8'h42;
    step(0, 0, 0, 0, 1, 0, "R5 wildcard match");
    step(0, 1, 4'd12, 0, 0, 0, "R5 wildcard sets alarm flag");
    step(0, 0, 0, 0, 0, 1, "R6 tick");
    step(0, 1, 4'd12, 0, 0, 1, "R9 tick collides with read");
    step(0, 1, 4'd12, 0, 0, 0, "R9 periodic flag survived read");
    step(0, 1, 4'd12, 0, 0, 0, "R8 cleared after read");
    step(1, 0, 4'd11, 8'h00, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 1, "R10 flags with enables clear");
    step(0, 1, 4'd12, 0, 0, 0, "R10 flags visible, bit 7 low");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      int k;
      k = $urandom_range(0, 9);
      a = (k < 4) ? 4'd12 : 4'($urandom_range(0, 15));
      d = ($urandom_range(0, 3) == 0) ? 8'hC0 | 8'($urandom_range(0, 63)) : 8'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) a = 4'd11;
      sec = 8'($urandom_range(0, 3)); min = 8'($urandom_range(0, 3)); hour = 8'($urandom_range(0, 3));
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, "R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule